// File: doc/BRIEF.md
# Multi-Lane Serial Peripheral Master

This block is a serial-peripheral master that moves 8-bit packets over one, two or four data lanes. Software-side logic pushes 16-bit command words into a transmit queue. Each word carries a data byte and a set of tag bits. The tag bits select the lane count, the transfer direction and whether the frame closes after the byte. The engine takes words from the queue one at a time. It drives an idle-low serial clock, an active-low frame select and the data lanes, and it sets each lane's output enable to match the word being shifted. Bytes it captures are stored in a receive queue.

A frame opens when a word is taken while the engine is idle. The frame stays open across any number of words and closes only after a word that carries the end flag has been fully shifted. If the transmit queue runs dry in the middle of a frame, the frame select stays low and the serial clock stops until another word arrives. The serial clock rate is set by a half-period input, counted in system clock cycles. The engine supports one clocking scheme: the clock idles low, data is captured on the rising edge, and the next group is launched on the falling edge.

Top module: `mlspi_master`

## Requirements
- R1: A command word holds the data byte in bits [7:0], the lane-mode code in bits [15:13], the end flag in bit 12 and the direction in bit 11 (1 = receive). Bits 10:8 are ignored. Data leaves MSB first, and within each clock group the highest-numbered active lane carries the most significant bit.
- R2: Code 1 (dual) shifts 2 bits per clock on lanes 1:0, taking 4 clocks per byte. Code 2 (quad) shifts 4 bits per clock on lanes 3:0, taking 2 clocks. Code 3 (single) shifts 1 bit per clock on lane 0, taking 8 clocks.
- R3: `cs_n` falls when a word is taken while idle. It stays low across the following words and rises only after the last falling clock edge of a word whose end flag is set.
- R4: When the transmit queue empties in mid-frame, `cs_n` stays low and `sclk` stays low with no pulses. Shifting resumes when a new word is written.
- R5: A word with direction 0 in any mode, including single-lane transmit, never writes to the receive queue.
- R6: Receive words store the captured byte in bits [7:0] of a receive entry, with bits [15:8] zero. Dual and quad receive capture lanes 1:0 and 3:0. Single-lane receive (code 3, direction 1) is full duplex: it sends on lane 0 and captures lane 1.
- R7: `sclk` is low whenever `cs_n` is high. During shifting, each high phase and each low phase lasts `half_div` system clocks (a value of 0 acts as 1). Inputs are sampled at the rising edge.
- R8: `lane_oe` is 0 while `cs_n` is high and during dual or quad receive. Otherwise it is 0001 for single-lane, 0011 for dual transmit and 1111 for quad transmit.
- R9: `busy` is high exactly while `cs_n` is low.
- R10: A mode code of 0, 4, 5, 6 or 7 is shifted as a single-lane transmit, whatever its direction bit, and sets `mode_err`. `mode_err` stays set until reset.
- R11: After reset, `cs_n`=1, `sclk`=0, `lane_oe`=0, `busy`=0, `mode_err`=0 and the receive queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | DIVW | Serial clock half-period in system clocks |
| tx_wr_en | input | 1 | Push a command word |
| tx_wr_data | input | 16 | Command word |
| tx_full | output | 1 | Transmit queue full; pushes are dropped |
| rx_rd_en | input | 1 | Pop the receive head |
| rx_rd_data | output | 16 | Receive head (show-ahead) |
| rx_empty | output | 1 | Receive queue empty |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Frame select, active low |
| lane_out | output | 4 | Lane output values |
| lane_oe | output | 4 | Lane output enables |
| lane_in | input | 4 | Lane input values |
| busy | output | 1 | Frame open |
| mode_err | output | 1 | Sticky invalid-mode flag |

## Verification
Several properties are checked on every cycle: the clock stays quiet and the lanes are released while the frame is closed, `busy` tracks `cs_n`, the error flag never clears, and a receive push only follows a capturing word. Other behaviour can only be shown by the bench scenarios. These include the bit order on each lane width, the data captured in each receive mode, the exact clock count per byte, the half-period length, a frame that survives an empty queue, and an invalid code being treated as a transmit.

// File: rtl/qlm_pkg.sv
package qlm_pkg;

  localparam int ENTRY_W = 16;
  localparam int BYTE_W  = 8;
  localparam int NLANE   = 4;

  typedef enum logic [1:0] {
    LW_SINGLE = 2'd0,
    LW_DUAL   = 2'd1,
    LW_QUAD   = 2'd2
  } lane_w_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_WAIT = 2'd3
  } eng_st_e;

  function automatic lane_w_e width_of(input logic [2:0] code);
    case (code)
      3'd1:    width_of = LW_DUAL;
      3'd2:    width_of = LW_QUAD;
      default: width_of = LW_SINGLE;
    endcase
  endfunction

  function automatic int lanes_of(input lane_w_e w);
    case (w)
      LW_DUAL: lanes_of = 2;
      LW_QUAD: lanes_of = 4;
      default: lanes_of = 1;
    endcase
  endfunction

  function automatic logic [3:0] groups_of(input lane_w_e w);
    case (w)
      LW_DUAL: groups_of = 4'd4;
      LW_QUAD: groups_of = 4'd2;
      default: groups_of = 4'd8;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] shl_group(input logic [BYTE_W-1:0] s,
                                                  input lane_w_e w);
    case (w)
      LW_DUAL: shl_group = {s[5:0], 2'b00};
      LW_QUAD: shl_group = {s[3:0], 4'b0000};
      default: shl_group = {s[6:0], 1'b0};
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] cap_merge(input logic [BYTE_W-1:0] r,
                                                  input lane_w_e w,
                                                  input logic [NLANE-1:0] li);
    case (w)
      LW_DUAL: cap_merge = {r[5:0], li[1:0]};
      LW_QUAD: cap_merge = {r[3:0], li[3:0]};
      default: cap_merge = {r[6:0], li[1]};
    endcase
  endfunction

endpackage

// File: rtl/qlm_fifo.sv
module qlm_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic             do_wr, do_rd;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/qlm_lane_mux.sv
module qlm_lane_mux
  import qlm_pkg::*;
(
  input  logic [BYTE_W-1:0] sh,
  input  lane_w_e           width,
  input  logic              hd_rx,
  output logic [NLANE-1:0]  out_bits,
  output logic [NLANE-1:0]  oe
);
  int act;
  always_comb act = lanes_of(width);

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    always_comb begin
      if (i < act) begin
        out_bits[i] = sh[BYTE_W - act + i];
        oe[i]       = !hd_rx;
      end else begin
        out_bits[i] = 1'b0;
        oe[i]       = 1'b0;
      end
    end
  end
endmodule

// File: rtl/qlm_shift_engine.sv
module qlm_shift_engine
  import qlm_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIVW-1:0]    half_div,
  input  logic [ENTRY_W-1:0] tx_entry,
  input  logic               tx_empty,
  output logic               tx_pop,
  input  logic [NLANE-1:0]   lane_in,
  output logic               rx_push,
  output logic [ENTRY_W-1:0] rx_wdata,
  output logic               sclk,
  output logic               cs_n,
  output logic [NLANE-1:0]   lane_out,
  output logic [NLANE-1:0]   lane_oe,
  output logic               busy,
  output logic               err
);
  eng_st_e           state;
  logic [DIVW-1:0]   cnt, hlim;
  logic [BYTE_W-1:0] sh_tx, sh_rx, mux_sh;
  logic [3:0]        steps;
  lane_w_e           cur_w, ent_w, mux_w;
  logic              cur_hd_rx, cur_cap, cur_eom;
  logic              phase_end, last_grp, fall_now, load_now;
  logic [2:0]        ent_code;
  logic              ent_ok, ent_dir, ent_hd_rx, ent_cap, mux_hd;
  logic [NLANE-1:0]  mux_out, mux_oe;

  // entry tag decode
  always_comb begin
    ent_code  = tx_entry[15:13];
    ent_dir   = tx_entry[11];
    ent_ok    = (ent_code >= 3'd1) && (ent_code <= 3'd3);
    ent_w     = width_of(ent_code);
    ent_hd_rx = ent_ok && ent_dir && (ent_code != 3'd3);
    ent_cap   = ent_ok && ent_dir;
  end

  always_comb begin
    hlim      = (half_div == '0) ? DIVW'(1) : half_div;
    phase_end = (cnt >= hlim - 1'b1);
    last_grp  = (steps == 4'd1);
    fall_now  = (state == ST_HIGH) && phase_end;
    load_now  = !tx_empty && ((state == ST_IDLE) || (state == ST_WAIT) ||
                              (fall_now && last_grp && !cur_eom));
    tx_pop    = load_now;
    mux_sh    = load_now ? tx_entry[BYTE_W-1:0] : shl_group(sh_tx, cur_w);
    mux_w     = load_now ? ent_w : cur_w;
    mux_hd    = load_now ? ent_hd_rx : cur_hd_rx;
  end

  qlm_lane_mux u_mux (
    .sh      (mux_sh),
    .width   (mux_w),
    .hd_rx   (mux_hd),
    .out_bits(mux_out),
    .oe      (mux_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sh_tx     <= '0;
      sh_rx     <= '0;
      steps     <= '0;
      cur_w     <= LW_SINGLE;
      cur_hd_rx <= 1'b0;
      cur_cap   <= 1'b0;
      cur_eom   <= 1'b0;
      sclk      <= 1'b0;
      cs_n      <= 1'b1;
      busy      <= 1'b0;
      lane_out  <= '0;
      lane_oe   <= '0;
      err       <= 1'b0;
      rx_push   <= 1'b0;
      rx_wdata  <= '0;
    end else begin
      rx_push <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (load_now) begin
            cs_n  <= 1'b0;
            busy  <= 1'b1;
            state <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (phase_end) begin
            cnt   <= '0;
            sclk  <= 1'b1;
            sh_rx <= cap_merge(sh_rx, cur_w, lane_in);
            state <= ST_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (phase_end) begin
            cnt  <= '0;
            sclk <= 1'b0;
            if (!last_grp) begin
              steps <= steps - 1'b1;
              state <= ST_LOW;
            end else begin
              rx_push  <= cur_cap;
              rx_wdata <= {{(ENTRY_W-BYTE_W){1'b0}}, sh_rx};
              if (cur_eom) begin
                cs_n    <= 1'b1;
                busy    <= 1'b0;
                lane_oe <= '0;
                state   <= ST_IDLE;
              end else if (load_now) begin
                state <= ST_LOW;
              end else begin
                state <= ST_WAIT;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (load_now) state <= ST_LOW;
        end
      endcase

      if (load_now) begin
        sh_tx     <= mux_sh;
        cur_w     <= ent_w;
        cur_hd_rx <= ent_hd_rx;
        cur_cap   <= ent_cap;
        cur_eom   <= tx_entry[12];
        steps     <= groups_of(ent_w);
        lane_out  <= mux_out;
        lane_oe   <= mux_oe;
        cnt       <= '0;
        if (!ent_ok) err <= 1'b1;
      end else if (fall_now && !last_grp) begin
        sh_tx    <= mux_sh;
        lane_out <= mux_out;
        lane_oe  <= mux_oe;
      end
    end
  end

  AST_CLK_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk); // R7
  AST_LANES_RELEASED: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (lane_oe == '0)); // R8
  AST_BUSY_TRACKS_CS: assert property (@(posedge clk) disable iff (rst)
    busy == !cs_n); // R9
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R10
  AST_PUSH_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> $past(cur_cap)); // R5
endmodule

// File: rtl/mlspi_master.sv
module mlspi_master
  import qlm_pkg::*;
#(
  parameter int DIVW     = 8,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIVW-1:0]    half_div,
  input  logic               tx_wr_en,
  input  logic [ENTRY_W-1:0] tx_wr_data,
  output logic               tx_full,
  input  logic               rx_rd_en,
  output logic [ENTRY_W-1:0] rx_rd_data,
  output logic               rx_empty,
  output logic               sclk,
  output logic               cs_n,
  output logic [NLANE-1:0]   lane_out,
  output logic [NLANE-1:0]   lane_oe,
  input  logic [NLANE-1:0]   lane_in,
  output logic               busy,
  output logic               mode_err
);
  logic [ENTRY_W-1:0] tx_head, rx_wdata;
  logic               tx_empty, tx_pop, rx_push, rx_full;

  qlm_fifo #(.WIDTH(ENTRY_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .wr_en(tx_wr_en), .wr_data(tx_wr_data), .full(tx_full),
    .rd_en(tx_pop), .rd_data(tx_head), .empty(tx_empty)
  );

  qlm_shift_engine #(.DIVW(DIVW)) u_eng (
    .clk(clk), .rst(rst), .half_div(half_div),
    .tx_entry(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
    .lane_in(lane_in), .rx_push(rx_push), .rx_wdata(rx_wdata),
    .sclk(sclk), .cs_n(cs_n), .lane_out(lane_out), .lane_oe(lane_oe),
    .busy(busy), .err(mode_err)
  );

  qlm_fifo #(.WIDTH(ENTRY_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .wr_en(rx_push), .wr_data(rx_wdata), .full(rx_full),
    .rd_en(rx_rd_en), .rd_data(rx_rd_data), .empty(rx_empty)
  );

  AST_RX_HIGH_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rx_empty |-> (rx_rd_data[15:8] == 8'h00)); // R6
endmodule

// File: tb/tb_mlspi_master.sv
module tb_mlspi_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  half_div = 8'd2;
  logic        tx_wr_en = 1'b0;
  logic [15:0] tx_wr_data = '0;
  logic        tx_full;
  logic        rx_rd_en = 1'b0;
  logic [15:0] rx_rd_data;
  logic        rx_empty;
  logic        sclk, cs_n, busy, mode_err;
  logic [3:0]  lane_out, lane_oe, lane_in;

  always #2 clk = ~clk;

  mlspi_master dut (
    .clk(clk), .rst(rst), .half_div(half_div),
    .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_full(tx_full),
    .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty),
    .sclk(sclk), .cs_n(cs_n), .lane_out(lane_out), .lane_oe(lane_oe),
    .lane_in(lane_in), .busy(busy), .mode_err(mode_err)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench-side peripheral model and monitor
  int          cur_l = 1;
  int          cur_kind = 0;   // 0 transmit, 1 half-duplex receive, 2 duplex
  logic [3:0]  exp_oe = '0;
  logic [31:0] slave_word = '0;
  int          sidx = 0, edges = 0, oe_bad = 0, cs_rises = 0;
  int          hi_cnt = 0, lo_cnt = 0, last_hi = 0, last_lo = 0;
  logic [15:0] mon_tx = '0;
  logic        sclk_q = 1'b0, cs_q = 1'b1;

  always_comb begin
    logic [31:0] s;
    s = slave_word << (sidx * cur_l);
    if (cur_kind == 2)      lane_in = {2'b00, s[31], 1'b0};
    else if (cur_kind == 1) lane_in = (cur_l == 4) ? s[31:28] : {2'b00, s[31:30]};
    else                    lane_in = 4'b0000;
  end

  always @(negedge clk) begin
    if (sclk) begin
      if (!sclk_q) begin
        last_lo = lo_cnt;
        hi_cnt = 0;
        edges++;
        if (lane_oe !== exp_oe) oe_bad++;
        if (cur_l == 4)      mon_tx = {mon_tx[11:0], lane_out};
        else if (cur_l == 2) mon_tx = {mon_tx[13:0], lane_out[1:0]};
        else                 mon_tx = {mon_tx[14:0], lane_out[0]};
      end
      hi_cnt++;
    end else begin
      if (sclk_q) begin
        last_hi = hi_cnt;
        lo_cnt = 0;
        sidx++;
      end
      lo_cnt++;
    end
    if (cs_n && !cs_q) cs_rises++;
    sclk_q = sclk;
    cs_q = cs_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    tx_wr_en = 1'b1;
    tx_wr_data = w;
    @(negedge clk);
    tx_wr_en = 1'b0;
  endtask

  task automatic setup(input int l, input int kind, input logic [3:0] oe,
                       input logic [7:0] slv);
    cur_l = l; cur_kind = kind; exp_oe = oe;
    slave_word = {slv, 24'h0};
    sidx = 0; edges = 0; oe_bad = 0; mon_tx = '0;
  endtask

  task automatic wait_frame_end();
    int n = 0;
    while (!busy && n < 200) begin @(negedge clk); n++; end
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(n < 5000, "R3 frame end", n, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic pop_rx();
    @(negedge clk);
    rx_rd_en = 1'b1;
    @(negedge clk);
    rx_rd_en = 1'b0;
  endtask

  // entry: [15:13] code, [12] end, [11] dir, [7:0] data
  localparam int NV = 6;
  localparam logic [15:0] V_ENTRY [NV] = '{16'h30A5, 16'h503C, 16'h7096,
                                          16'h3800, 16'h5800, 16'h7869};
  localparam int          V_LANES [NV] = '{2, 4, 1, 2, 4, 1};
  localparam int          V_KIND  [NV] = '{0, 0, 0, 1, 1, 2};
  localparam logic [3:0]  V_OE    [NV] = '{4'h3, 4'hF, 4'h1, 4'h0, 4'h0, 4'h1};
  localparam logic [7:0]  V_SLAVE [NV] = '{8'h00, 8'h00, 8'h00, 8'h5E, 8'hE1, 8'hC3};

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int rises0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(cs_n === 1'b1 && sclk === 1'b0, "R11 cs/sclk", {cs_n, sclk}, 2'b10);
    chk(lane_oe === 4'h0 && busy === 1'b0, "R11 oe/busy", {lane_oe, busy}, 0);
    chk(mode_err === 1'b0 && rx_empty === 1'b1, "R11 err/rx", {mode_err, rx_empty}, 1);

    // table walk: R1 R2 R5 R6 R8 R3
    for (int i = 0; i < NV; i++) begin
      setup(V_LANES[i], V_KIND[i], V_OE[i], V_SLAVE[i]);
      rises0 = cs_rises;
      push(V_ENTRY[i]);
      wait_frame_end();
      chk(edges == 8 / V_LANES[i], "R2 clock count", edges, 8 / V_LANES[i]);
      chk(oe_bad == 0, "R8 lane enables", oe_bad, 0);
      chk(cs_rises == rises0 + 1, "R3 single close", cs_rises - rises0, 1);
      chk(lane_oe === 4'h0, "R8 released after frame", lane_oe, 0);
      if (V_KIND[i] != 1)
        chk(mon_tx[7:0] == V_ENTRY[i][7:0], "R1 bit order", mon_tx[7:0], V_ENTRY[i][7:0]);
      if (V_KIND[i] == 0) begin
        chk(rx_empty === 1'b1, "R5 no receive write", rx_empty, 1);
      end else begin
        chk(!rx_empty && rx_rd_data == {8'h00, V_SLAVE[i]}, "R6 captured byte",
            rx_rd_data, {8'h00, V_SLAVE[i]});
        pop_rx();
      end
    end

    // R4 queue underrun inside a frame, R9 busy
    setup(4, 0, 4'hF, 8'h00);
    rises0 = cs_rises;
    push(16'h405A);
    for (int n = 0; n < 200 && edges < 2; n++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(cs_n === 1'b0 && sclk === 1'b0, "R4 hold frame", {cs_n, sclk}, 0);
    chk(edges == 2, "R4 no pulses", edges, 2);
    chk(busy === 1'b1, "R9 busy in frame", busy, 1);
    push(16'h50C7);
    wait_frame_end();
    chk(mon_tx == 16'h5AC7, "R4 resume data", mon_tx, 16'h5AC7);
    chk(cs_rises == rises0 + 1, "R3 one close", cs_rises - rises0, 1);
    chk(busy === 1'b0, "R9 busy cleared", busy, 0);

    // R3 two words queued back to back, single-lane
    setup(1, 0, 4'h1, 8'h00);
    rises0 = cs_rises;
    push(16'h6011);
    push(16'h7022);
    wait_frame_end();
    chk(edges == 16 && mon_tx == 16'h1122, "R3 multi-word frame", mon_tx, 16'h1122);
    chk(cs_rises == rises0 + 1, "R3 no early close", cs_rises - rises0, 1);

    // R7 half-period length
    half_div = 8'd3;
    setup(1, 0, 4'h1, 8'h00);
    push(16'h7055);
    wait_frame_end();
    chk(last_hi == 3, "R7 high phase", last_hi, 3);
    chk(last_lo == 3, "R7 low phase", last_lo, 3);
    chk(mon_tx[7:0] == 8'h55, "R7 data at slower rate", mon_tx[7:0], 8'h55);
    half_div = 8'd2;

    // R10 invalid code with receive direction -> single-lane transmit
    chk(mode_err === 1'b0, "R10 flag clear before", mode_err, 0);
    setup(1, 0, 4'h1, 8'h00);
    push(16'hF8AB);
    wait_frame_end();
    chk(edges == 8 && mon_tx[7:0] == 8'hAB, "R10 sent as single lane", mon_tx[7:0], 8'hAB);
    chk(oe_bad == 0, "R10 lane0 driven", oe_bad, 0);
    chk(rx_empty === 1'b1, "R10 no receive write", rx_empty, 1);
    chk(mode_err === 1'b1, "R10 flag set", mode_err, 1);
    setup(2, 0, 4'h3, 8'h00);
    push(16'h3099);
    wait_frame_end();
    chk(mode_err === 1'b1, "R10 flag sticky", mode_err, 1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule